// File: doc/BRIEF.md
# Ping-pong isochronous buffer status tracker

This block keeps the status of two isochronous data buffers that a host processor and a frame-driven transfer engine use in turn. The processor fills a buffer and reports the write as complete, which marks the buffer full and locks it against further writes. The engine works on one buffer per frame, alternating between them, and reports when it has consumed the data. That marks the buffer done. A processor read of a buffer releases it and clears both of its bits.

Each start-of-frame tick advances the engine's buffer selection and raises an isochronous interrupt, which stays set until the processor clears it. The block flags a missed deadline in a sticky overrun bit. A deadline is missed when a done buffer has not been read by the next start-of-frame, or when the previous interrupt is still pending as the next one is raised. The number of buffers is a parameter. The default of two gives the ping-pong arrangement.

Top module: `iso_pingpong_status`

## Requirements
- R1: After reset, all full and done bits, irq_o and overrun_o are 0, every wr_allow_o bit is 1 and eng_sel_o is NBUF-1, so that the first start-of-frame selects buffer 0.
- R2: A write completion (cpu_wr_i) for a buffer whose full bit is 0 sets that full bit in the next cycle. wr_allow_o for a buffer is the inverse of its full bit.
- R3: A write completion for a buffer whose full bit is 1 is ignored. Its full and done bits keep their values.
- R4: eng_done_i sets the done bit of the buffer selected by eng_sel_o in the next cycle, but only if that buffer is full. If the buffer is empty, eng_done_i has no effect. eng_go_o is 1 exactly when the selected buffer is full and not yet done.
- R5: A read completion (cpu_rd_i) clears the full and done bits of the buffer it names in the next cycle. In the same cycle, a read takes priority over an engine completion on the same buffer. If a write and a read name an empty buffer in the same cycle, that buffer ends up full.
- R6: Each sof_i pulse advances eng_sel_o by one, wrapping from NBUF-1 to 0, so with two buffers the selection alternates.
- R7: sof_i sets irq_o in the next cycle. irq_o then stays 1 until irq_clr_i. If sof_i and irq_clr_i arrive in the same cycle, irq_o remains 1.
- R8: overrun_o is set at a sof_i if any done bit is 1 and that buffer is not being read in the same cycle.
- R9: overrun_o is set at a sof_i if irq_o is 1 and irq_clr_i is not asserted in that cycle. overrun_o stays set until ovr_clr_i. A new overrun in the same cycle as ovr_clr_i leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sof_i | input | 1 | Start-of-frame tick |
| cpu_wr_i | input | 1 | Processor finished writing a buffer |
| cpu_wr_sel_i | input | IDX_W | Buffer index of the write |
| cpu_rd_i | input | 1 | Processor finished reading a buffer |
| cpu_rd_sel_i | input | IDX_W | Buffer index of the read |
| eng_done_i | input | 1 | Engine finished the selected buffer |
| irq_clr_i | input | 1 | Processor clears the isochronous interrupt |
| ovr_clr_i | input | 1 | Clears the overrun flag |
| full_o | output | NBUF | Per-buffer full bits |
| done_o | output | NBUF | Per-buffer done bits |
| wr_allow_o | output | NBUF | Per-buffer write permission |
| eng_sel_o | output | IDX_W | Buffer the engine handles this frame |
| eng_go_o | output | 1 | Selected buffer holds data to process |
| irq_o | output | 1 | Isochronous interrupt |
| overrun_o | output | 1 | Sticky missed-deadline flag |

## Verification
Several functions of the block can fall in the same cycle, and these collisions are the hard cases:
- a start-of-frame tick meets the processor's interrupt clear;
- a start-of-frame tick meets a buffer read, which decides whether a deadline counts as missed;
- an engine completion and a processor read hit one buffer;
- a write and a read hit one buffer.

Directed steps place each of these pairs on a single edge. A random phase then makes every input likely to coincide. A behavioural model in the bench predicts every output on every cycle. The judgement in each case is whether the clear, the read, or the new frame takes effect.

// File: rtl/iso_pp_pkg.sv
package iso_pp_pkg;

  typedef struct packed {
    logic full;
    logic done;
  } slot_st_t;

endpackage

// File: rtl/iso_pp_slot.sv
module iso_pp_slot
  import iso_pp_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     wr_i,
  input  logic     rd_i,
  input  logic     proc_i,
  output slot_st_t st_o,
  output logic     late_o
);

  slot_st_t st_q, st_d;
  logic     wr_ok, proc_ok;

  // writes only land in an empty slot; reads beat engine completion
  assign wr_ok   = wr_i & ~st_q.full;
  assign proc_ok = proc_i & st_q.full & ~st_q.done & ~rd_i;

  always_comb begin
    st_d.full = (st_q.full & ~rd_i) | wr_ok;
    st_d.done = (st_q.done & ~rd_i) | proc_ok;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= st_d;
  end

  assign st_o   = st_q;
  assign late_o = st_q.done & ~rd_i;

endmodule

// File: rtl/iso_pp_frame_seq.sv
module iso_pp_frame_seq #(
  parameter int NBUF  = 2,
  parameter int IDX_W = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sof_i,
  input  logic             irq_clr_i,
  input  logic             ovr_clr_i,
  input  logic             late_any_i,
  output logic [IDX_W-1:0] sel_o,
  output logic             irq_o,
  output logic             overrun_o
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(NBUF - 1);

  logic [IDX_W-1:0] sel_q;
  logic             irq_q, ovr_q;
  logic             irq_stale, ovr_hit;

  assign irq_stale = irq_q & ~irq_clr_i;
  assign ovr_hit   = sof_i & (late_any_i | irq_stale);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= LAST;
      irq_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      if (sof_i) sel_q <= (sel_q == LAST) ? '0 : sel_q + 1'b1;
      irq_q <= sof_i | irq_stale;
      if (ovr_hit)        ovr_q <= 1'b1;
      else if (ovr_clr_i) ovr_q <= 1'b0;
    end
  end

  assign sel_o     = sel_q;
  assign irq_o     = irq_q;
  assign overrun_o = ovr_q;

endmodule

// File: rtl/iso_pingpong_status.sv
module iso_pingpong_status
  import iso_pp_pkg::*;
#(
  parameter int NBUF  = 2,
  parameter int IDX_W = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sof_i,
  input  logic             cpu_wr_i,
  input  logic [IDX_W-1:0] cpu_wr_sel_i,
  input  logic             cpu_rd_i,
  input  logic [IDX_W-1:0] cpu_rd_sel_i,
  input  logic             eng_done_i,
  input  logic             irq_clr_i,
  input  logic             ovr_clr_i,
  output logic [NBUF-1:0]  full_o,
  output logic [NBUF-1:0]  done_o,
  output logic [NBUF-1:0]  wr_allow_o,
  output logic [IDX_W-1:0] eng_sel_o,
  output logic             eng_go_o,
  output logic             irq_o,
  output logic             overrun_o
);

  slot_st_t [NBUF-1:0] st;
  logic     [NBUF-1:0] late;
  logic     [IDX_W-1:0] sel;

  for (genvar b = 0; b < NBUF; b++) begin : g_slot
    logic wr_hit, rd_hit, proc_hit;
    assign wr_hit   = cpu_wr_i   & (cpu_wr_sel_i == IDX_W'(b));
    assign rd_hit   = cpu_rd_i   & (cpu_rd_sel_i == IDX_W'(b));
    assign proc_hit = eng_done_i & (sel == IDX_W'(b));

    iso_pp_slot u_slot (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (wr_hit),
      .rd_i   (rd_hit),
      .proc_i (proc_hit),
      .st_o   (st[b]),
      .late_o (late[b])
    );

    assign full_o[b]     = st[b].full;
    assign done_o[b]     = st[b].done;
    assign wr_allow_o[b] = ~st[b].full;
  end

  iso_pp_frame_seq #(
    .NBUF  (NBUF),
    .IDX_W (IDX_W)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sof_i      (sof_i),
    .irq_clr_i  (irq_clr_i),
    .ovr_clr_i  (ovr_clr_i),
    .late_any_i (|late),
    .sel_o      (sel),
    .irq_o      (irq_o),
    .overrun_o  (overrun_o)
  );

  assign eng_sel_o = sel;
  assign eng_go_o  = st[sel].full & ~st[sel].done;

endmodule

// File: rtl/iso_pingpong_status_chk.sv
module iso_pingpong_status_chk #(
  parameter int NBUF  = 2,
  parameter int IDX_W = 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sof_i,
  input logic             cpu_wr_i,
  input logic [IDX_W-1:0] cpu_wr_sel_i,
  input logic             cpu_rd_i,
  input logic [IDX_W-1:0] cpu_rd_sel_i,
  input logic             eng_done_i,
  input logic             irq_clr_i,
  input logic             ovr_clr_i,
  input logic [NBUF-1:0]  full_o,
  input logic [NBUF-1:0]  done_o,
  input logic [IDX_W-1:0] eng_sel_o,
  input logic             irq_o,
  input logic             overrun_o
);

  for (genvar b = 0; b < NBUF; b++) begin : g_b
    AST_FULL_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cpu_wr_i && cpu_wr_sel_i == IDX_W'(b) && !full_o[b] |=> full_o[b]); // R2
    AST_FULL_WRITE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cpu_wr_i && cpu_wr_sel_i == IDX_W'(b) && full_o[b]
      && !(cpu_rd_i && cpu_rd_sel_i == IDX_W'(b)) |=> full_o[b]); // R3
    AST_DONE_NEEDS_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o[b] |-> full_o[b]); // R4
    AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cpu_rd_i && cpu_rd_sel_i == IDX_W'(b) |=> !done_o[b]); // R5
  end

  AST_SEL_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_i |=> eng_sel_o != $past(eng_sel_o)); // R6
  AST_SEL_STEADY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sof_i |=> $stable(eng_sel_o)); // R6
  AST_IRQ_ON_SOF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_i |=> irq_o); // R7
  AST_IRQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !irq_clr_i |=> irq_o); // R7
  AST_OVR_LATE_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_i && irq_o && !irq_clr_i |=> overrun_o); // R9
  AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o && !ovr_clr_i |=> overrun_o); // R9

endmodule

bind iso_pingpong_status iso_pingpong_status_chk #(
  .NBUF  (NBUF),
  .IDX_W (IDX_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sof_i        (sof_i),
  .cpu_wr_i     (cpu_wr_i),
  .cpu_wr_sel_i (cpu_wr_sel_i),
  .cpu_rd_i     (cpu_rd_i),
  .cpu_rd_sel_i (cpu_rd_sel_i),
  .eng_done_i   (eng_done_i),
  .irq_clr_i    (irq_clr_i),
  .ovr_clr_i    (ovr_clr_i),
  .full_o       (full_o),
  .done_o       (done_o),
  .eng_sel_o    (eng_sel_o),
  .irq_o        (irq_o),
  .overrun_o    (overrun_o)
);

// File: tb/iso_pingpong_status_bench.sv
`timescale 1ns/1ps
module iso_pingpong_status_bench;

  localparam int NB = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sof = 0, wr = 0, rd = 0, edone = 0, iclr = 0, oclr = 0;
  logic [0:0] wsel = 0, rsel = 0;
  logic [NB-1:0] full, done, wallow;
  logic [0:0] esel;
  logic go, irq, ovr;

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;

  // reference model state
  int m_full[NB], m_done[NB];
  int m_ptr, m_irq, m_ovr;

  always #5 clk = ~clk;

  iso_pingpong_status u_iso_pingpong_status (
    .clk_i(clk), .rst_ni(rst_n), .sof_i(sof),
    .cpu_wr_i(wr), .cpu_wr_sel_i(wsel), .cpu_rd_i(rd), .cpu_rd_sel_i(rsel),
    .eng_done_i(edone), .irq_clr_i(iclr), .ovr_clr_i(oclr),
    .full_o(full), .done_o(done), .wr_allow_o(wallow), .eng_sel_o(esel),
    .eng_go_o(go), .irq_o(irq), .overrun_o(ovr)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_full[i]) begin m_full[i] = 0; m_done[i] = 0; end
      m_ptr = NB - 1; m_irq = 0; m_ovr = 0;
    end else begin
      int late, nptr;
      late = 0;
      for (int i = 0; i < NB; i++)
        if (m_done[i] != 0 && !(rd && rsel == i)) late = 1;
      if (sof && (late != 0 || (m_irq != 0 && !iclr))) m_ovr = 1;
      else if (oclr) m_ovr = 0;
      if (sof) m_irq = 1;
      else if (iclr) m_irq = 0;
      nptr = sof ? (m_ptr + 1) % NB : m_ptr;
      for (int i = 0; i < NB; i++) begin
        bit hit_rd, hit_wr, hit_eng;
        int was_full;
        hit_rd  = rd && rsel == i;
        hit_wr  = wr && wsel == i;
        hit_eng = edone && m_ptr == i;
        was_full = m_full[i];
        if (hit_rd) begin m_full[i] = 0; m_done[i] = 0; end
        else if (hit_eng && was_full != 0) m_done[i] = 1;
        if (hit_wr && was_full == 0) m_full[i] = 1;
      end
      m_ptr = nptr;
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d (cycle %0d)", tag, got, exp, cyc);
    end
  endtask

  task automatic compare_all();
    for (int i = 0; i < NB; i++) begin
      chk("R2 full", int'(full[i]), m_full[i]);
      chk("R2 wr_allow", int'(wallow[i]), m_full[i] == 0 ? 1 : 0);
      chk("R4 done", int'(done[i]), m_done[i]);
    end
    chk("R6 eng_sel", int'(esel), m_ptr);
    chk("R4 eng_go", int'(go), (m_full[m_ptr] != 0 && m_done[m_ptr] == 0) ? 1 : 0);
    chk("R7 irq", int'(irq), m_irq);
    chk("R8/R9 overrun", int'(ovr), m_ovr);
  endtask

  // drive for one cycle, then compare at the next falling edge
  task automatic step(input bit s, input bit w, input int ws, input bit r,
                      input int rs, input bit e, input bit ic, input bit oc);
    sof = s; wr = w; wsel = ws[0]; rd = r; rsel = rs[0];
    edone = e; iclr = ic; oclr = oc;
    @(posedge clk);
    @(negedge clk);
    cyc++;
    sof = 0; wr = 0; rd = 0; edone = 0; iclr = 0; oclr = 0;
    compare_all();
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 full", int'(full), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 wr_allow", int'(wallow), 3);
    chk("R1 irq", int'(irq), 0);
    chk("R1 overrun", int'(ovr), 0);
    chk("R1 eng_sel", int'(esel), NB - 1);
    rst_n = 1;
    @(negedge clk);
    compare_all();

    step(0,1,0,0,0,0,0,0); chk("R2 full0 set", int'(full[0]), 1);
    chk("R2 wr_allow0", int'(wallow[0]), 0);
    step(0,1,0,0,0,0,0,0); chk("R3 full0 kept", int'(full[0]), 1);
    chk("R3 done0 kept", int'(done[0]), 0);
    step(1,0,0,0,0,0,0,0); chk("R6 sel to 0", int'(esel), 0);
    chk("R7 irq raised", int'(irq), 1);
    chk("R4 go", int'(go), 1);
    step(0,0,0,0,0,1,1,0); chk("R4 done0 set", int'(done[0]), 1);
    chk("R7 irq cleared", int'(irq), 0);
    step(1,0,0,0,0,0,0,0); chk("R8 overrun from done", int'(ovr), 1);
    chk("R6 sel to 1", int'(esel), 1);
    step(0,0,0,0,0,1,0,1); chk("R4 eng on empty ignored", int'(done[1]), 0);
    chk("R9 overrun cleared", int'(ovr), 0);
    step(0,0,0,1,0,0,0,0); chk("R5 full0 cleared", int'(full[0]), 0);
    chk("R5 done0 cleared", int'(done[0]), 0);
    step(1,0,0,0,0,0,1,0); chk("R7 irq stays on sof+clr", int'(irq), 1);
    chk("R9 no overrun when cleared", int'(ovr), 0);
    step(1,0,0,0,0,0,0,0); chk("R9 overrun stale irq", int'(ovr), 1);
    step(1,0,0,0,0,0,0,1); chk("R9 set beats clear", int'(ovr), 1);
    step(0,0,0,0,0,0,1,1); chk("R9 clear", int'(ovr), 0);
    // esel now 0: read versus engine on buffer 0
    step(0,1,0,0,0,0,0,0);
    step(0,0,0,1,0,1,0,0); chk("R5 read beats engine", int'(done[0]), 0);
    chk("R5 read clears full", int'(full[0]), 0);
    step(0,1,1,1,1,0,0,0); chk("R5 write+read empty", int'(full[1]), 1);
    // done read at the sof edge is not late
    step(1,0,0,0,0,0,1,0); // sel to 1
    step(0,0,0,0,0,1,1,0); chk("R4 done1", int'(done[1]), 1);
    step(1,0,0,1,1,0,1,0); chk("R8 read at sof not late", int'(ovr), 0);

    for (int n = 0; n < 4000; n++) begin
      step(($urandom % 8) == 0, ($urandom % 3) == 0, $urandom % 2,
           ($urandom % 4) == 0, $urandom % 2, ($urandom % 3) == 0,
           ($urandom % 4) == 0, ($urandom % 16) == 0);
    end
    report();
  end

endmodule